// File: doc/BRIEF.md
# Four-Way Set-Associative Cache with LRU Replacement

This block is a write-back data cache placed between a processor and a word-wide memory. Each set holds four ways of one word, and every line has a valid bit, a dirty bit and a tag. On each request the four stored tags of the addressed set are compared in parallel. The one-hot match vector then selects the read word through a 4-to-1 AND-OR multiplexer. A hit completes in the same cycle as the request.

On a miss the block raises `stall` and picks a victim way. It uses an invalid way when one exists, and otherwise the least recently used way of the set. A dirty victim is first written to memory over the write port. The missing word is then read over the read port and installed. On the next cycle the held request hits and completes. Writes that miss allocate a line the same way, and the write then lands as a hit. Recency is kept per set as an age order of the four ways.

The processor must hold its request stable while `stall` is high. Each memory request stays asserted until its acknowledge is seen on a rising clock edge.

Top module: `setassoc_cache`

## Requirements
- R1: The address splits into tag (bits 31 down to SET_W+2), set index (bits SET_W+1..2) and byte offset (bits 1..0). The offset does not affect lookup. Equal tags in different sets occupy separate lines.
- R2: If a request's tag matches a valid way of its set while the block is idle, `rsp_hit` is high and `stall` is low in that same cycle, and `rsp_rdata` is that way's word.
- R3: A request that matches no valid way has `stall` high and `rsp_hit` low from its first cycle until the line is installed. The held request then hits on the cycle after the fill acknowledge.
- R4: A miss issues exactly one memory read at the request's word address, with the two low bits zero. `mem_rd_req` and `mem_rd_addr` stay unchanged until `mem_rd_ack`.
- R5: When a set still has an invalid way, a fill goes to an invalid way, so up to four distinct tags in one set all remain resident.
- R6: When all four ways are valid, a miss replaces the way least recently hit or filled. Every hit or fill makes the accessed way the most recent.
- R7: A write hit updates only the cached word and marks it dirty. It produces no memory traffic, and a later read returns the written value.
- R8: When a dirty victim is replaced, its address and word are written to memory before the fill read, held until `mem_wr_ack`. A clean victim causes no memory write. Reads and writes to memory are never requested together.
- R9: A write miss fetches the word, installs it, then overwrites it and marks it dirty. A later read returns the written value.
- R10: After reset no line is valid and no memory request is pending, so the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| rsp_rdata | output | 32 | Read word, valid when `rsp_hit` |
| rsp_hit | output | 1 | Request completes this cycle |
| stall | output | 1 | Request must be held |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read word address |
| mem_rd_ack | input | 1 | Read done; data valid |
| mem_rd_data | input | 32 | Memory read word |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory write word address |
| mem_wr_data | output | 32 | Memory write word |
| mem_wr_ack | input | 1 | Write accepted |

## Verification
Hit, data and stall are combinational in the request cycle. The bench drives each request just after a falling edge and samples these outputs one time unit later, before the next rising edge. Memory acknowledges come after a fixed two-cycle latency. Each ack takes effect at the following rising edge, and the bench polls `stall` at each falling edge until the held request shows a hit. The read data is sampled in that same cycle. Expected hit/miss and write-back counts come from a per-set recency list kept in the bench. Written-back words are compared against the processor's view of memory.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_FILL   = 2'd2
    } cache_state_e;
endpackage

// File: rtl/cache_way.sv
module cache_way #(
    parameter int SET_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  idx,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    output logic [DATA_W-1:0] line_data,
    input  logic              fill_en,
    input  logic              write_en,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic [DATA_W-1:0] new_data
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
    assign line_data  = data_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (write_en) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= new_tag;
            data_q[idx] <= new_data;
        end else if (write_en) begin
            data_q[idx] <= new_data;
        end
    end
endmodule

// File: rtl/cache_match.sv
module cache_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]   way_valid,
    input  logic [TAG_W-1:0]  way_tag  [WAYS],
    input  logic [DATA_W-1:0] way_data [WAYS],
    input  logic [TAG_W-1:0]  look_tag,
    output logic              any_hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] hit_data
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    assign any_hit = |match;

    always_comb begin
        hit_data = '0;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_data = hit_data | ({DATA_W{match[w]}} & way_data[w]);
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int SET_W  = 8,
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SETS  = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] idx,
    input  logic [WAYS-1:0]  way_valid,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    // age 0 = most recent, WAYS-1 = least recent; always a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] age_d [WAYS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
                age_d[w] = '0;
            else if (age_q[idx][w] < age_q[idx][touch_way])
                age_d[w] = age_q[idx][w] + 1'b1;
            else
                age_d[w] = age_q[idx][w];
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[idx][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++)
                age_q[idx][w] <= age_d[w];
        end
    end
endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 8,
    parameter int WAYS   = 4,
    localparam int OFF_W = 2,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_hit,
    output logic              stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    import cache_pkg::*;

    typedef struct packed {
        cache_state_e     state;
        logic [WAY_W-1:0] victim;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [TAG_W-1:0]  req_tag;
    logic [SET_W-1:0]  req_idx;
    logic [WAYS-1:0]   way_valid, way_dirty, fill_en, write_en;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [DATA_W-1:0] way_data [WAYS];
    logic [DATA_W-1:0] new_data;
    logic              any_hit, touch_en, hit_now;
    logic [WAY_W-1:0]  hit_way, lru_victim, touch_way;
    logic [DATA_W-1:0] hit_data;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFF_W +: SET_W];
    assign new_data = (ctrl_q.state == ST_FILL) ? mem_rd_data : req_wdata;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .idx       (req_idx),
            .line_valid(way_valid[w]),
            .line_dirty(way_dirty[w]),
            .line_tag  (way_tag[w]),
            .line_data (way_data[w]),
            .fill_en   (fill_en[w]),
            .write_en  (write_en[w]),
            .new_tag   (req_tag),
            .new_data  (new_data)
        );
    end

    cache_match #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
        .way_valid(way_valid),
        .way_tag  (way_tag),
        .way_data (way_data),
        .look_tag (req_tag),
        .any_hit  (any_hit),
        .hit_way  (hit_way),
        .hit_data (hit_data)
    );

    cache_lru #(.SET_W(SET_W), .WAYS(WAYS)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .way_valid(way_valid),
        .touch_en (touch_en),
        .touch_way(touch_way),
        .victim   (lru_victim)
    );

    always_comb begin
        ctrl_d     = ctrl_q;
        fill_en    = '0;
        write_en   = '0;
        touch_en   = 1'b0;
        touch_way  = hit_way;
        hit_now    = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        unique case (ctrl_q.state)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (any_hit) begin
                        hit_now  = 1'b1;
                        touch_en = 1'b1;
                        if (req_write) write_en[hit_way] = 1'b1;
                    end else begin
                        ctrl_d.victim = lru_victim;
                        ctrl_d.state  = (way_valid[lru_victim] && way_dirty[lru_victim])
                                        ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_wr_req = 1'b1;
                if (mem_wr_ack) ctrl_d.state = ST_FILL;
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                touch_way  = ctrl_q.victim;
                if (mem_rd_ack) begin
                    fill_en[ctrl_q.victim] = 1'b1;
                    touch_en               = 1'b1;
                    ctrl_d.state           = ST_LOOKUP;
                end
            end
            default: ctrl_d.state = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{state: ST_LOOKUP, victim: '0};
        else        ctrl_q <= ctrl_d;
    end

    assign rsp_hit     = hit_now;
    assign rsp_rdata   = hit_data;
    assign stall       = req_valid && !hit_now;
    assign mem_rd_addr = {req_tag, req_idx, {OFF_W{1'b0}}};
    assign mem_wr_addr = {way_tag[ctrl_q.victim], req_idx, {OFF_W{1'b0}}};
    assign mem_wr_data = way_data[ctrl_q.victim];
endmodule

// File: rtl/setassoc_cache_chk.sv
module setassoc_cache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_hit,
    input logic              stall,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ack,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_wr_ack
);
    p_hit_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !stall);

    p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_hit) |-> stall);

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    p_hit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (!mem_rd_req && !mem_wr_req));

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)));

    p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ack) |=> mem_rd_req);
endmodule

bind setassoc_cache setassoc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/setassoc_cache_bench.sv
module setassoc_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW   = 2;
    localparam int NS   = 1 << SW;
    localparam int TW   = 32 - SW - 2;
    localparam int LAT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_hit, stall;
    logic        mem_rd_req, mem_wr_req;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, rlat = 0, wlat = 0;
    logic [31:0] cur_addr = '0;
    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] cpu_img [logic [31:0]];

    // recency model: position 0 = most recent
    logic [TW-1:0] m_tag [NS][4];
    bit            m_dirty [NS][4];
    int            m_cnt [NS];

    setassoc_cache #(.SET_W(SW)) u_setassoc_cache (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0001_9E37) ^ 32'h5A00_0013;
    endfunction

    function automatic logic [31:0] cpu_view(input logic [31:0] a);
        return cpu_img.exists(a) ? cpu_img[a] : pat(a);
    endfunction

    function automatic logic [31:0] adr(input int t, input int s);
        return (32'(t) << (SW + 2)) | (32'(s) << 2);
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // memory model with fixed latency, driven away from the rising edge
    always @(negedge clk) begin
        mem_rd_ack = 1'b0;
        mem_wr_ack = 1'b0;
        if (mem_wr_req) begin
            if (wlat == LAT) begin
                wlat = 0;
                mem_wr_ack = 1'b1;
                check(mem_wr_data == cpu_view(mem_wr_addr), "R8 write-back word",
                      mem_wr_data, cpu_view(mem_wr_addr));
                mem_img[mem_wr_addr] = mem_wr_data;
                wr_cnt++;
            end else wlat++;
        end else if (mem_rd_req) begin
            if (rlat == LAT) begin
                rlat = 0;
                mem_rd_ack = 1'b1;
                mem_rd_data = mem_img.exists(mem_rd_addr) ? mem_img[mem_rd_addr] : pat(mem_rd_addr);
                check(mem_rd_addr == (cur_addr & ~32'd3), "R4 fill address",
                      mem_rd_addr, cur_addr & ~32'd3);
                rd_cnt++;
            end else rlat++;
        end
    end

    task automatic model_access(input logic [31:0] a, input bit wr, output bit hit, output bit wb);
        int s, p;
        logic [TW-1:0] t;
        bit d;
        s = int'(a[SW+1:2]);
        t = a[31:SW+2];
        p = -1;
        for (int i = 0; i < m_cnt[s]; i++) if (m_tag[s][i] == t) p = i;
        hit = (p >= 0);
        wb  = 1'b0;
        if (hit) begin
            d = m_dirty[s][p] | wr;
            for (int i = p; i > 0; i--) begin
                m_tag[s][i] = m_tag[s][i-1];
                m_dirty[s][i] = m_dirty[s][i-1];
            end
        end else begin
            d = wr;
            if (m_cnt[s] == 4) wb = m_dirty[s][3];
            else m_cnt[s]++;
            for (int i = 3; i > 0; i--) begin
                m_tag[s][i] = m_tag[s][i-1];
                m_dirty[s][i] = m_dirty[s][i-1];
            end
        end
        m_tag[s][0] = t;
        m_dirty[s][0] = d;
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd, output bit first_hit);
        bit exp_hit, exp_wb;
        int rd0, wr0;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        model_access(a, wr, exp_hit, exp_wb);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        cur_addr  = a;
        #1;
        first_hit = rsp_hit;
        check(rsp_hit == exp_hit, "R2 hit in request cycle", 32'(rsp_hit), 32'(exp_hit));
        if (!exp_hit) check(stall == 1'b1, "R3 stall on miss", 32'(stall), 32'd1);
        while (stall) begin
            @(negedge clk);
            #1;
        end
        check(rsp_hit == 1'b1, "R3 held request completes", 32'(rsp_hit), 32'd1);
        if (!wr) check(rsp_rdata == cpu_view(a & ~32'd3), "R2 read word", rsp_rdata, cpu_view(a & ~32'd3));
        check(rd_cnt - rd0 == int'(!exp_hit), "R4 one fill read per miss", 32'(rd_cnt - rd0), 32'(!exp_hit));
        check(wr_cnt - wr0 == int'(exp_wb), "R8 write-back only for dirty victim", 32'(wr_cnt - wr0), 32'(exp_wb));
        @(posedge clk);
        if (wr) cpu_img[a & ~32'd3] = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        bit h;
        int w0;
        logic [31:0] lfsr;
        for (int s = 0; s < NS; s++) m_cnt[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!stall && !rsp_hit && !mem_rd_req && !mem_wr_req, "R10 idle after reset",
              {28'd0, stall, rsp_hit, mem_rd_req, mem_wr_req}, 32'd0);

        // R10: cold miss; R1: offset ignored
        access(1'b0, adr(5, 1), 0, h);
        check(h == 1'b0, "R10 first access misses", 32'(h), 32'd0);
        access(1'b0, adr(5, 1) | 32'd3, 0, h);
        check(h == 1'b1, "R1 byte offset ignored", 32'(h), 32'd1);
        access(1'b0, adr(5, 0), 0, h);
        check(h == 1'b0, "R1 same tag other set is separate", 32'(h), 32'd0);

        // R5: four tags coexist in set 2
        for (int t = 1; t <= 4; t++) access(1'b0, adr(t, 2), 0, h);
        for (int t = 1; t <= 4; t++) begin
            access(1'b0, adr(t, 2), 0, h);
            check(h == 1'b1, "R5 fills use invalid ways", 32'(h), 32'd1);
        end

        // R6: touch tag 1, new tag 5 evicts tag 2
        access(1'b0, adr(1, 2), 0, h);
        access(1'b0, adr(5, 2), 0, h);
        access(1'b0, adr(1, 2), 0, h);
        check(h == 1'b1, "R6 recently used way kept", 32'(h), 32'd1);
        access(1'b0, adr(2, 2), 0, h);
        check(h == 1'b0, "R6 least recent way replaced", 32'(h), 32'd0);

        // R7: write hit stays in cache
        access(1'b0, adr(7, 3), 0, h);
        w0 = wr_cnt;
        access(1'b1, adr(7, 3), 32'hCAFE_0007, h);
        check(h == 1'b1 && wr_cnt == w0, "R7 write hit no memory write", 32'(wr_cnt - w0), 32'd0);
        access(1'b0, adr(7, 3), 0, h);
        check(rsp_rdata == 32'hCAFE_0007, "R7 read after write hit", rsp_rdata, 32'hCAFE_0007);

        // R9: write miss allocates
        access(1'b1, adr(9, 3), 32'hBEEF_0009, h);
        check(h == 1'b0, "R9 write miss detected", 32'(h), 32'd0);
        access(1'b0, adr(9, 3), 0, h);
        check(h == 1'b1 && rsp_rdata == 32'hBEEF_0009, "R9 allocated and written", rsp_rdata, 32'hBEEF_0009);

        // R8: push both dirty lines out of set 3
        w0 = wr_cnt;
        for (int t = 10; t <= 13; t++) access(1'b0, adr(t, 3), 0, h);
        check(wr_cnt - w0 == 2, "R8 two dirty victims written back", 32'(wr_cnt - w0), 32'd2);
        access(1'b0, adr(7, 3), 0, h);
        check(rsp_rdata == 32'hCAFE_0007, "R8 refetched written-back word", rsp_rdata, 32'hCAFE_0007);
        idle();

        // sweep: 6 tags x all sets, mixed reads and writes
        lfsr = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            access(lfsr[20], adr(int'(lfsr[27:24]) % 6 + 20, int'(lfsr[17:16])),
                   lfsr ^ 32'h0F0F_F0F0, h);
            if (lfsr[9:7] == 3'd0) idle();
        end
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule